// File: doc/BRIEF.md
# Eight-Bit Timer/Counter with Waveform Output

This block is an 8-bit counter with a single compare unit, controlled through a small register bus. It counts ticks that come from one of several divided taps of a free-running 10-bit prescaler, or from edges on an external event pin. The count source is selected by the control register. The counter can run freely, restart from zero after reaching the compare value, or sweep up and down for phase-correct pulse-width modulation. A fourth mode toggles the output pin on every compare match, which produces a square wave.

Two events are recorded in sticky flags: counter overflow and compare match. Each flag has its own mask bit, and the masked flags are combined into one interrupt request. Software clears a flag by writing a one to its bit. In the up/down mode the compare value is double-buffered so that a new duty cycle starts cleanly at the top of the sweep.

Top module: `tmr8_pwm`

## Requirements
- R1: After reset, the control, counter, compare and flag registers read 0, and both the waveform output and the interrupt request are low.
- R2: The bus map is: address 0 is control, 1 is counter, 2 is compare, 3 is flags. Control bits [2:0] select the count source: 000 holds the counter (no counting), 001 counts every cycle, 010 every 8th, 011 every 64th, 100 every 256th, 101 every 1024th. The divided taps come from one free-running prescaler, so any run of k·N cycles contains exactly k ticks.
- R3: Source 110 counts falling edges and source 111 counts rising edges of `ext_pin`. The pin passes through a two-flop synchronizer, and each qualifying edge adds exactly one count.
- R4: With control bits [4:3] = 00 (free-running), the counter counts up and wraps from 0xFF to 0x00. The wrap sets flag bit 0 (overflow).
- R5: With bits [4:3] = 01 (clear on match), a tick that finds the counter equal to the compare value loads zero. This gives a period of compare+1 ticks.
- R6: With bits [4:3] = 10 (phase-correct), the counter runs 0 up to 0xFF and back down to 0, turning around at each end, for a period of 510 ticks. The turn at the bottom sets the overflow flag. A compare match clears the output while counting up and sets it while counting down.
- R7: In phase-correct mode, a write to the compare register is read back at once but reaches the comparator only at the top of the sweep. In the other modes it applies from the next cycle.
- R8: With bits [4:3] = 11 (frequency generator), the counter counts as in R5 and the output toggles on each compare match.
- R9: In every mode, a tick that finds the counter equal to the compare value sets flag bit 1 (compare match).
- R10: Writing 1 to a flag bit clears it. If a flag event and a clearing write fall in the same cycle, the flag stays set.
- R11: `irq` is high when overflow flag bit 0 is set with control bit 5, or when compare flag bit 1 is set with control bit 6.
- R12: A control write drives the output low and resets the sweep direction to up. A counter write loads the value and takes the place of that cycle's tick and events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 1 | External event input, asynchronous |
| bus_addr | input | 2 | Register select |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| wave_out | output | 1 | Waveform output |
| irq | output | 1 | Masked interrupt request |

## Verification
A flag-clearing write from software can land in the same cycle as the hardware event that sets that flag. The bench starts the counter at a known edge. It then counts cycles so that a write of 1 to the compare flag is sampled at the very edge where the counter reaches the compare value. The flag must still read set afterwards. A second clearing write, with no event in that cycle, must then clear it. The double-buffered compare update in phase-correct mode raises a similar question. A write made on the downward slope must not change where the output is set on that same slope.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

    typedef enum logic [1:0] {
        MODE_FREE = 2'b00,
        MODE_CLR  = 2'b01,
        MODE_PWM  = 2'b10,
        MODE_FGEN = 2'b11
    } tmr_mode_e;

    typedef enum logic [2:0] {
        SRC_OFF    = 3'd0,
        SRC_DIV1   = 3'd1,
        SRC_DIV8   = 3'd2,
        SRC_DIV64  = 3'd3,
        SRC_DIV256 = 3'd4,
        SRC_DIV1K  = 3'd5,
        SRC_EXT_FL = 3'd6,
        SRC_EXT_RS = 3'd7
    } tmr_src_e;

    typedef struct packed {
        logic      rsvd;
        logic      cmp_en;
        logic      ovf_en;
        tmr_mode_e mode;
        tmr_src_e  src;
    } tmr_ctrl_t;

    typedef struct packed {
        logic cmp;
        logic ovf;
    } tmr_evt_t;

    localparam logic [1:0] ADR_CTRL = 2'd0;
    localparam logic [1:0] ADR_CNT  = 2'd1;
    localparam logic [1:0] ADR_CMP  = 2'd2;
    localparam logic [1:0] ADR_FLAG = 2'd3;

    localparam int NUM_TAPS = 4;

    function automatic int tap_shift(input int idx);
        case (idx)
            0:       return 3;
            1:       return 6;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/tmr8_prescale.sv
module tmr8_prescale
    import tmr8_pkg::*;
#(
    parameter int PRE_W = 10
) (
    input  logic                clk,
    input  logic                rst,
    output logic [NUM_TAPS-1:0] taps
);
    logic [PRE_W-1:0] pre;

    always_ff @(posedge clk) begin
        if (rst) pre <= '0;
        else     pre <= pre + 1'b1;
    end

    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        localparam int SH = tap_shift(g);
        assign taps[g] = (pre[SH-1:0] == {SH{1'b1}});
    end
endmodule

// File: rtl/tmr8_edge_sync.sv
module tmr8_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], pin};
    end

    assign rise =  sh[STAGES-1] & ~sh[STAGES];
    assign fall = ~sh[STAGES-1] &  sh[STAGES];
endmodule

// File: rtl/tmr8_count.sv
module tmr8_count
    import tmr8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  tmr_mode_e    mode,
    input  logic         ctrl_wr,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_wdata,
    input  logic [W-1:0] cmp_buf,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cmp_act,
    output logic         wave,
    output tmr_evt_t     evt
);
    localparam logic [W-1:0] TOPV = {W{1'b1}};
    localparam logic [W-1:0] BOTV = '0;

    logic         down, down_n;
    logic [W-1:0] cnt_n;
    logic         step, hit, at_top;

    assign step   = tick && !cnt_wr;
    assign hit    = step && (cnt == cmp_act);
    assign at_top = step && !down && (cnt == TOPV);

    always_comb begin
        cnt_n   = cnt;
        down_n  = down;
        evt.ovf = 1'b0;
        evt.cmp = hit;
        if (cnt_wr) begin
            cnt_n = cnt_wdata;
        end else if (tick) begin
            case (mode)
                MODE_PWM: begin
                    if (!down) begin
                        if (cnt == TOPV) begin
                            down_n = 1'b1;
                            cnt_n  = cnt - 1'b1;
                        end else begin
                            cnt_n = cnt + 1'b1;
                        end
                    end else begin
                        if (cnt == BOTV) begin
                            down_n  = 1'b0;
                            cnt_n   = cnt + 1'b1;
                            evt.ovf = 1'b1;
                        end else begin
                            cnt_n = cnt - 1'b1;
                        end
                    end
                end
                MODE_CLR, MODE_FGEN: begin
                    cnt_n   = (cnt == cmp_act) ? BOTV : cnt + 1'b1;
                    evt.ovf = (cnt == TOPV);
                end
                default: begin
                    cnt_n   = cnt + 1'b1;
                    evt.ovf = (cnt == TOPV);
                end
            endcase
        end
        if (ctrl_wr) down_n = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            down <= 1'b0;
        end else begin
            cnt  <= cnt_n;
            down <= down_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                  cmp_act <= '0;
        else if (mode != MODE_PWM) cmp_act <= cmp_buf;
        else if (at_top)          cmp_act <= cmp_buf;
    end

    always_ff @(posedge clk) begin
        if (rst)          wave <= 1'b0;
        else if (ctrl_wr) wave <= 1'b0;
        else if (hit) begin
            case (mode)
                MODE_PWM:  wave <= down;
                MODE_FGEN: wave <= ~wave;
                default:   wave <= wave;
            endcase
        end
    end
endmodule

// File: rtl/tmr8_pwm.sv
module tmr8_pwm
    import tmr8_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PRE_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_pin,
    input  logic [1:0]       bus_addr,
    input  logic             bus_we,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             wave_out,
    output logic             irq
);
    localparam int FLAG_W = $bits(tmr_evt_t);

    tmr_ctrl_t           ctrl;
    logic [CNT_W-1:0]    cmp_buf, cnt, cmp_act;
    logic [FLAG_W-1:0]   flags, flag_clr;
    logic [NUM_TAPS-1:0] taps;
    logic                ext_rise, ext_fall, tick;
    logic                ctrl_wr, cnt_wr, cmp_wr, flag_wr;
    tmr_evt_t            evt;

    assign ctrl_wr = bus_we && (bus_addr == ADR_CTRL);
    assign cnt_wr  = bus_we && (bus_addr == ADR_CNT);
    assign cmp_wr  = bus_we && (bus_addr == ADR_CMP);
    assign flag_wr = bus_we && (bus_addr == ADR_FLAG);

    tmr8_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk (clk),
        .rst (rst),
        .taps(taps)
    );

    tmr8_edge_sync #(.STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .pin (ext_pin),
        .rise(ext_rise),
        .fall(ext_fall)
    );

    always_comb begin
        case (ctrl.src)
            SRC_DIV1:   tick = 1'b1;
            SRC_DIV8:   tick = taps[0];
            SRC_DIV64:  tick = taps[1];
            SRC_DIV256: tick = taps[2];
            SRC_DIV1K:  tick = taps[3];
            SRC_EXT_FL: tick = ext_fall;
            SRC_EXT_RS: tick = ext_rise;
            default:    tick = 1'b0;
        endcase
    end

    tmr8_count #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .mode     (ctrl.mode),
        .ctrl_wr  (ctrl_wr),
        .cnt_wr   (cnt_wr),
        .cnt_wdata(bus_wdata),
        .cmp_buf  (cmp_buf),
        .cnt      (cnt),
        .cmp_act  (cmp_act),
        .wave     (wave_out),
        .evt      (evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            cmp_buf <= '0;
        end else begin
            if (ctrl_wr) ctrl    <= tmr_ctrl_t'({1'b0, bus_wdata[6:0]});
            if (cmp_wr)  cmp_buf <= bus_wdata;
        end
    end

    assign flag_clr = flag_wr ? bus_wdata[FLAG_W-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~flag_clr) | evt;
    end

    assign irq = (flags[0] & ctrl.ovf_en) | (flags[1] & ctrl.cmp_en);

    always_comb begin
        case (bus_addr)
            ADR_CTRL: bus_rdata = ctrl;
            ADR_CNT:  bus_rdata = cnt;
            ADR_CMP:  bus_rdata = cmp_buf;
            default:  bus_rdata = {{(CNT_W-FLAG_W){1'b0}}, flags};
        endcase
    end
endmodule

// File: rtl/tmr8_chk.sv
module tmr8_chk
    import tmr8_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input tmr_mode_e  mode,
    input tmr_src_e   src,
    input logic       ctrl_wr,
    input logic       cnt_wr,
    input logic [7:0] cnt,
    input logic [7:0] cmp_act,
    input logic [1:0] flags,
    input tmr_evt_t   evt,
    input logic       wave
);
    // R2
    src_off_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_OFF && !cnt_wr) |=> (cnt == $past(cnt)));

    // R10
    ovf_flag_chk: assert property (@(posedge clk) disable iff (rst)
        evt.ovf |=> flags[0]);

    // R9
    cmp_flag_chk: assert property (@(posedge clk) disable iff (rst)
        evt.cmp |=> flags[1]);

    // R6
    pwm_step_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_PWM && tick && !cnt_wr) |=>
        (cnt == $past(cnt) + 8'd1 || cnt == $past(cnt) - 8'd1));

    // R5
    clr_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CLR && tick && !cnt_wr && !ctrl_wr && cnt == cmp_act) |=> (cnt == 8'd0));

    // R12
    ctrl_low_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> !wave);

    // R8
    wave_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(wave) |-> $past(evt.cmp || ctrl_wr));
endmodule

bind tmr8_pwm tmr8_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .mode   (ctrl.mode),
    .src    (ctrl.src),
    .ctrl_wr(ctrl_wr),
    .cnt_wr (cnt_wr),
    .cnt    (cnt),
    .cmp_act(cmp_act),
    .flags  (flags),
    .evt    (evt),
    .wave   (wave_out)
);

// File: tb/tb_tmr8_pwm.sv
`timescale 1ns/1ps
module tb_tmr8_pwm;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_pin = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       wave_out, irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] rv;

    always #4 clk = ~clk;

    tmr8_pwm dut (
        .clk(clk), .rst(rst), .ext_pin(ext_pin),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .wave_out(wave_out), .irq(irq)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [7:0]  cmp;
        logic [15:0] n;
        logic [7:0]  cnt;
        logic [1:0]  fl;
        logic        wave;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 8'h80, 16'd10,  8'd10,  2'd0, 1'b0},
        '{2'd0, 8'h05, 16'd10,  8'd10,  2'd2, 1'b0},
        '{2'd0, 8'h80, 16'd260, 8'd4,   2'd3, 1'b0},
        '{2'd1, 8'h09, 16'd25,  8'd5,   2'd2, 1'b0},
        '{2'd1, 8'h09, 16'd5,   8'd5,   2'd0, 1'b0},
        '{2'd2, 8'h10, 16'd300, 8'd210, 2'd2, 1'b0},
        '{2'd2, 8'h10, 16'd500, 8'd10,  2'd2, 1'b1},
        '{2'd2, 8'h10, 16'd520, 8'd10,  2'd3, 1'b1},
        '{2'd3, 8'h03, 16'd10,  8'd2,   2'd2, 1'b0},
        '{2'd3, 8'h03, 16'd6,   8'd2,   2'd2, 1'b1}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic setup(input logic [7:0] cnt0, input logic [7:0] cmpv);
        wr(2'd0, 8'h00);
        wr(2'd1, cnt0);
        wr(2'd2, cmpv);
        wr(2'd3, 8'h03);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, rv); chk("R1 ctrl", rv, 0);
        rd(2'd1, rv); chk("R1 cnt", rv, 0);
        rd(2'd2, rv); chk("R1 cmp", rv, 0);
        rd(2'd3, rv); chk("R1 flags", rv, 0);
        chk("R1 wave", wave_out, 0);
        chk("R1 irq", irq, 0);

        // table: R4 R5 R6 R8 R9 across modes
        for (int i = 0; i < NV; i++) begin
            setup(8'd0, VEC[i].cmp);
            wr(2'd0, {3'b000, VEC[i].mode, 3'b001});
            repeat (int'(VEC[i].n)) @(negedge clk);
            rd(2'd1, rv); chk($sformatf("R4/R5/R6/R8 cnt vec%0d", i), rv, VEC[i].cnt);
            rd(2'd3, rv); chk($sformatf("R9/R4 flags vec%0d", i), rv, VEC[i].fl);
            chk($sformatf("R6/R8 wave vec%0d", i), wave_out, VEC[i].wave);
        end

        // R2 stopped source holds
        setup(8'h33, 8'h00);
        repeat (20) @(negedge clk);
        rd(2'd1, rv); chk("R2 stop hold", rv, 8'h33);

        // R2 prescaler taps
        setup(8'd0, 8'hFF);
        wr(2'd0, 8'h02);
        repeat (80) @(negedge clk);
        rd(2'd1, rv); chk("R2 div8", rv, 10);
        setup(8'd0, 8'hFF);
        wr(2'd0, 8'h03);
        repeat (640) @(negedge clk);
        rd(2'd1, rv); chk("R2 div64", rv, 10);
        setup(8'd0, 8'hFF);
        wr(2'd0, 8'h04);
        repeat (512) @(negedge clk);
        rd(2'd1, rv); chk("R2 div256", rv, 2);
        setup(8'd0, 8'hFF);
        wr(2'd0, 8'h05);
        repeat (2048) @(negedge clk);
        rd(2'd1, rv); chk("R2 div1024", rv, 2);

        // R3 external rising edges
        setup(8'd0, 8'hFF);
        wr(2'd0, 8'h07);
        for (int k = 0; k < 3; k++) begin
            ext_pin = 1'b1; repeat (6) @(negedge clk);
            ext_pin = 1'b0; repeat (6) @(negedge clk);
        end
        rd(2'd1, rv); chk("R3 rising", rv, 3);
        // R3 external falling edges
        setup(8'd0, 8'hFF);
        wr(2'd0, 8'h06);
        for (int k = 0; k < 2; k++) begin
            ext_pin = 1'b1; repeat (6) @(negedge clk);
            ext_pin = 1'b0; repeat (6) @(negedge clk);
        end
        ext_pin = 1'b1; repeat (6) @(negedge clk);
        rd(2'd1, rv); chk("R3 falling", rv, 2);
        ext_pin = 1'b0; repeat (4) @(negedge clk);

        // R11 interrupt gating
        setup(8'hFF, 8'h80);
        wr(2'd0, 8'h21);
        wr(2'd0, 8'h20);
        rd(2'd3, rv); chk("R4 wrap flag", rv, 1);
        chk("R11 irq on", irq, 1);
        wr(2'd0, 8'h40);
        chk("R11 irq masked", irq, 0);
        wr(2'd3, 8'h01);
        wr(2'd0, 8'h60);
        chk("R11 irq cleared", irq, 0);

        // R10 set wins over clear
        setup(8'd0, 8'h03);
        wr(2'd0, 8'h01);
        repeat (3) @(negedge clk);
        wr(2'd3, 8'h02);
        rd(2'd3, rv); chk("R10 set wins", rv & 8'h02, 2);
        wr(2'd3, 8'h02);
        rd(2'd3, rv); chk("R10 w1c", rv & 8'h02, 0);

        // R12 counter write replaces tick
        wr(2'd1, 8'h40);
        rd(2'd1, rv); chk("R12 cnt load", rv, 8'h40);
        @(negedge clk);
        rd(2'd1, rv); chk("R12 cnt resumes", rv, 8'h41);

        // R7 buffered compare in phase-correct mode
        setup(8'd0, 8'h40);
        wr(2'd0, 8'h11);
        repeat (298) @(negedge clk);
        wr(2'd2, 8'h20);
        rd(2'd2, rv); chk("R7 cmp readback", rv, 8'h20);
        repeat (161) @(negedge clk);
        rd(2'd1, rv); chk("R6 down count", rv, 50);
        chk("R7 old cmp used on slope", wave_out, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule